// File: doc/BRIEF.md
# Reload-Synchronized Clock Divider

This block divides a reference clock by a small programmable integer and drives the divided clock out through a glitch-free enable gate. It is programmed through two 32-bit registers. A single-cycle write port and a combinational read port give access to both. The ratio register holds a staged ratio. Writing that field does not touch the running divider.

A new ratio takes effect only after a handshake. Software sets the channel's reload-request bit, then raises the reload trigger bit in the control register. The block records the request and copies the staged ratio into the active divider at the end of the current output period. The staged value is mapped onto the legal set {4, 5, 6, 8} before it is applied: 1 to 4 become 4, 5 stays 5, 6 stays 6, and 7 or more become 8. A staged value of zero is rejected, and the active ratio stays as it was. Software then clears the control request bits so that a later trigger can be recognised.

The enable bit is read back from the same control bit that software writes. A change of enable reaches the output only while the divided clock is in its low phase.

Top module: `clkdiv_reload_top`

## Requirements
- R1: After reset the active ratio is 8 and the output is enabled. The divided output starts with its high phase. The control register reads 0x0200_0000 and the ratio register reads 0x0000_0800.
- R2: With active ratio N, the divided output repeats every N reference cycles. It is high for floor(N/2) cycles and low for ceil(N/2) cycles.
- R3: A write to the ratio register at byte offset 0x8 stores bits [13:8] as the staged ratio and does not change the output period.
- R4: A reload happens only on a control write (offset 0x0) that sets bit 8 (trigger) while bit 1 (reload request) is set in the same write data. A trigger written with bit 1 clear leaves the period unchanged.
- R5: A recorded reload takes effect at the next end of an output period. The period in progress completes with the old ratio.
- R6: On reload, a staged value of 1 to 4 gives ratio 4, 5 gives 5, 6 gives 6, and 7 to 63 gives 8.
- R7: On reload, a staged value of 0 leaves the active ratio unchanged.
- R8: Control bit 25 is the output enable and reads back as written. When it is cleared, the high phase in progress completes in full and the output then stays low. When it is set again, the output resumes with whole high phases.
- R9: A reload is recognised only when the trigger bit goes from 0 to 1. Writing the trigger again while it is still set does not reload. Clearing the control register returns the block to idle.
- R10: The ratio register reads the staged field at bits [13:8] with all other bits 0. Addresses other than 0x0 and 0x8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 4 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| div_clk | output | 1 | Gated divided clock |

## Verification
The bench builds the block with its default parameters: request bit 1, trigger bit 8, enable offset 24, and a 6-bit ratio field at bit 8. With these values every legal ratio can be reached, and so can both clamp ends, including the field maximum 63 and the rejected value 0. The bench writes a trigger exactly at a period start, which shows that the old period completes. It clears the enable during a high phase, which shows that the gate never truncates a pulse.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 4;
  localparam int RAT_W   = 6;
  localparam int RAT_LSB = 8;
  localparam int DEF_RAT = 8;

  // Map a staged request onto the legal ratio set; 0 means rejected.
  function automatic logic [RAT_W-1:0] legal_ratio(input logic [RAT_W-1:0] req);
    if (req == '0)                 return '0;
    else if (req <= RAT_W'(4))     return RAT_W'(4);
    else if (req == RAT_W'(5))     return RAT_W'(5);
    else if (req == RAT_W'(6))     return RAT_W'(6);
    else                           return RAT_W'(8);
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int REQ_BIT   = 1,
  parameter int TRIG_BIT  = 8,
  parameter int EN_OFS    = 24,
  parameter int RAT_ADDR  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [RAT_W-1:0]  staged,
  output logic              en_bit,
  output logic              reload_req
);
  localparam int EN_BIT = REQ_BIT + EN_OFS;

  logic req_q, trig_q, en_q;
  logic [RAT_W-1:0] stg_q;
  logic ctrl_wr, rat_wr;

  assign ctrl_wr = wr_en && (addr == '0);
  assign rat_wr  = wr_en && (addr == ADDR_W'(RAT_ADDR));

  // Reload fires on a rising trigger that carries the request bit.
  assign reload_req = ctrl_wr && wdata[TRIG_BIT] && wdata[REQ_BIT] && !trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      trig_q <= 1'b0;
      en_q   <= 1'b1;
      stg_q  <= RAT_W'(DEF_RAT);
    end else begin
      if (ctrl_wr) begin
        req_q  <= wdata[REQ_BIT];
        trig_q <= wdata[TRIG_BIT];
        en_q   <= wdata[EN_BIT];
      end
      if (rat_wr) stg_q <= wdata[RAT_LSB +: RAT_W];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      rdata[REQ_BIT]  = req_q;
      rdata[TRIG_BIT] = trig_q;
      rdata[EN_BIT]   = en_q;
    end else if (addr == ADDR_W'(RAT_ADDR)) begin
      rdata[RAT_LSB +: RAT_W] = stg_q;
    end
  end

  assign staged = stg_q;
  assign en_bit = en_q;

  p_req_needs_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> req_q);
  p_trig_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> trig_q);
  p_stage_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rat_wr |=> $stable(stg_q));
endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RAT_W-1:0] staged,
  input  logic             reload_req,
  input  logic             en_bit,
  output logic             div_clk
);
  logic [RAT_W-1:0] cnt_q, act_q, half, next_rat;
  logic pend_q, gate_q, wrap, hi_phase;

  assign half     = act_q >> 1;
  assign wrap     = (cnt_q == act_q - RAT_W'(1));
  assign hi_phase = (cnt_q < half);
  assign next_rat = legal_ratio(staged);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= RAT_W'(DEF_RAT);
      pend_q <= 1'b0;
      gate_q <= 1'b1;
    end else begin
      pend_q <= reload_req | (pend_q & ~wrap);
      if (wrap) begin
        cnt_q <= '0;
        if (pend_q && next_rat != '0) act_q <= next_rat;
      end else begin
        cnt_q <= cnt_q + RAT_W'(1);
      end
      // Gate follows the enable only in the low phase.
      if (!hi_phase) gate_q <= en_bit;
    end
  end

  assign div_clk = hi_phase & gate_q;

  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < act_q);
  p_legal_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == 4) || (act_q == 5) || (act_q == 6) || (act_q == 8));
  p_hold_mid_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(act_q));
  p_gate_in_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hi_phase |=> $stable(gate_q));
endmodule

// File: rtl/clkdiv_reload_top.sv
module clkdiv_reload_top
  import clkdiv_pkg::*;
#(
  parameter int REQ_BIT  = 1,
  parameter int TRIG_BIT = 8,
  parameter int EN_OFS   = 24,
  parameter int RAT_ADDR = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic              div_clk
);
  logic [RAT_W-1:0] staged;
  logic en_bit, reload_req;

  clkdiv_regs #(
    .REQ_BIT(REQ_BIT), .TRIG_BIT(TRIG_BIT), .EN_OFS(EN_OFS), .RAT_ADDR(RAT_ADDR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .staged(staged), .en_bit(en_bit), .reload_req(reload_req)
  );

  clkdiv_core u_core (
    .clk(clk), .rst_n(rst_n), .staged(staged), .reload_req(reload_req),
    .en_bit(en_bit), .div_clk(div_clk)
  );
endmodule

// File: tb/sim_clkdiv_reload_top.sv
`timescale 1ns/1ps
module sim_clkdiv_reload_top;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic div_clk;
  int n_chk = 0, n_fail = 0;

  localparam logic [31:0] EN  = 32'h0200_0000;
  localparam logic [31:0] REQ = 32'h0000_0002;
  localparam logic [31:0] TRG = 32'h0000_0100;

  always #2.5 clk = ~clk;

  clkdiv_reload_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .div_clk(div_clk));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata; addr = '0;
  endtask

  // Sync to a rising output, then count high and low cycles (-1 on timeout).
  task automatic measure(output int hi, output int lo);
    int g = 0;
    hi = 0; lo = 0;
    while (div_clk && g < 64) begin g++; @(negedge clk); end
    while (!div_clk && g < 128) begin g++; @(negedge clk); end
    while (div_clk && hi < 64) begin hi++; @(negedge clk); end
    while (!div_clk && lo < 64) begin lo++; @(negedge clk); end
    if (g >= 128 || hi >= 64 || lo >= 64) begin hi = -1; lo = -1; end
  endtask

  task automatic reload(input logic [31:0] r);
    wr(4'h8, r << 8);
    wr(4'h0, EN | REQ);
    wr(4'h0, EN | REQ | TRG);
    wr(4'h0, EN);
  endtask

  task automatic expect_ratio(input string req, input int n);
    int hi, lo;
    measure(hi, lo);
    check(req, hi, n / 2);
    check(req, lo, n - n / 2);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 out high", int'(div_clk), 1);
    rd(4'h0, d); check("R1 ctrl", int'(d), int'(EN));
    rd(4'h8, d); check("R1 ratio", int'(d), 32'h800);
    expect_ratio("R1/R2 ratio8", 8);
  endtask

  task automatic t_stage_only;
    wr(4'h8, 32'd5 << 8);
    expect_ratio("R3 no change", 8);
    wr(4'h0, EN | TRG);                 // trigger without request
    expect_ratio("R4 no request", 8);
    wr(4'h0, EN);
  endtask

  task automatic t_boundary;
    int cyc = 0; logic prev = 1'b1;
    wr(4'h0, EN | REQ);
    while (div_clk) @(negedge clk);
    while (!div_clk) @(negedge clk);      // now at period start
    addr = 4'h0; wdata = EN | REQ | TRG; wr_en = 1'b1;
    do begin
      prev = div_clk; cyc++; @(negedge clk); wr_en = 1'b0;
    end while (!(div_clk && !prev) && cyc < 40);
    check("R5 old period completes", cyc, 8);
    wr(4'h0, EN);
    expect_ratio("R5/R2 odd ratio5", 5);
  endtask

  task automatic t_clamp;
    reload(2);  expect_ratio("R6 low clamp", 4);
    reload(6);  expect_ratio("R6 ratio6", 6);
    reload(63); expect_ratio("R6 high clamp", 8);
    reload(4);  expect_ratio("R6 ratio4", 4);
    reload(7);  expect_ratio("R6 seven", 8);
    reload(0);  expect_ratio("R7 zero rejected", 8);
  endtask

  task automatic t_retrigger;
    wr(4'h8, 32'd6 << 8);
    wr(4'h0, EN | REQ | TRG);
    expect_ratio("R9 first trigger", 6);
    wr(4'h8, 32'd4 << 8);
    wr(4'h0, EN | REQ | TRG);           // still set: no edge
    expect_ratio("R9 held trigger", 6);
    wr(4'h0, EN);
    wr(4'h0, EN | REQ | TRG);           // fresh edge after idle
    wr(4'h0, EN);
    expect_ratio("R9 after idle", 4);
  endtask

  task automatic t_gate;
    int hi = 0, ones = 0; logic [31:0] d;
    while (div_clk) @(negedge clk);
    while (!div_clk) @(negedge clk);
    wr(4'h0, 32'h0);                   // clear enable mid high phase
    hi = 1;
    while (div_clk && hi < 20) begin hi++; @(negedge clk); end
    check("R8 high not truncated", hi, 2);
    rd(4'h0, d); check("R8 readback off", int'(d), 0);
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (div_clk) ones++; end
    check("R8 gated low", ones, 0);
    wr(4'h0, EN);
    rd(4'h0, d); check("R8 readback on", int'(d), int'(EN));
    expect_ratio("R8 resumes whole", 4);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, d); check("R10 field only", int'(d), 32'h3F00);
    rd(4'h4, d); check("R10 unmapped", int'(d), 0);
    expect_ratio("R10 stage no effect", 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stage_only();
    t_boundary();
    t_clamp();
    t_retrigger();
    t_gate();
    t_readback();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule